// File: doc/BRIEF.md
# Subscriber Line State Controller

This block sits between a line-card host and a telephone line interface device that is steered by a four-bit parallel mode word (power-enable, burst-enable, feed-enable and polarity bits) and reports loop status on one active-low detector pin. The controller owns that word. It moves the line between power down, high-impedance idle feeding, active feeding (on-hook and off-hook), ring bursts and ring pauses. On request it also opens a metering-pulse window of an exact length.

The host gives level requests for line enable, polarity and ringing, plus a ring-frequency select. A single-cycle metering request carries its length in clock cycles. Burst, pause, hang-up and debounce lengths are tick counts on input ports. A tick is produced internally every `TICK_DIV` clocks. The ring waveform is made by the controller itself: during a burst it flips the polarity bit at each half period of the chosen ring frequency. A detector assertion during a burst is a ring trip. It stops the flipping at once and hands the line to the active off-hook state. A thermal-fault input forces the power-down word and freezes the controller, which resumes where it was when the fault clears.

Top module: `line_state_ctrl`

## Requirements
- R1: While reset is held, line_state is 0 (power down), the mode word {mode_pd,mode_d0,mode_d1,mode_d2} is 0000 and ring_rej is 0.
- R2: With line_en low the line goes to state 0 and the word is 0000. With line_en high, state 0 moves to idle (state 1) with word 1000. Whenever mode_d0 or mode_d1 is 1, mode_pd is 1.
- R3: det_n passes through two synchroniser flops and a debouncer. A new detector level is accepted only after it has differed from the accepted level on cfg_deb+1 consecutive ticks. A low pulse of one clock on det_n leaves the state unchanged.
- R4: In idle, an accepted off-hook (det_n low) moves the line to active off-hook (state 3) with word {1,0,1,pol_rev}.
- R5: In the active states (2 = on-hook, 3 = off-hook), mode_d2 equals pol_rev.
- R6: A ttx_req pulse with ttx_len = N, accepted in state 2 or 3, raises mode_d0 for exactly N consecutive clock cycles while mode_d1 stays 1. In any other state the request is dropped and mode_d0 stays 0.
- R7: From active on-hook (state 2) the line returns to idle (state 1) only after on-hook has lasted more than cfg_hang ticks, and only on a tick.
- R8: During a burst, mode_d2 flips every RING_HALF_SLOW ticks when ring_f25 is 0 and every RING_HALF_FAST ticks when ring_f25 is 1. The defaults are 25 and 20 ticks, which give 20 Hz and 25 Hz with a 1 ms tick.
- R9: A rising ring_en while on-hook in state 1 or 2 starts ringing. Ringing alternates between bursts (state 4, word {1,1,0,toggle}, toggle starting at 0) of cfg_burst ticks and pauses (state 5, word {1,0,1,pol_rev}) of cfg_pause ticks.
- R10: An accepted detector assertion in state 4 or 5 moves the line to state 3 on the next clock. mode_d2 then stops toggling and holds pol_rev.
- R11: A rising ring_en while the accepted detector reports off-hook does not start ringing and sets ring_rej to 1. ring_rej returns to 0 when ring_en goes low.
- R12: While therm_fault is high the word is 0000 from the next clock and line_state, timers and the ring toggle are frozen. When the fault clears, the line resumes the frozen state.
- R13: Lowering ring_en during state 4 or 5 ends ringing in active on-hook (state 2) when the line is on-hook.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_en | input | 1 | Line service enable; low forces power down |
| pol_rev | input | 1 | Polarity for active states; 1 selects reverse |
| ring_en | input | 1 | Ringing request, level; rising edge starts ringing |
| ring_f25 | input | 1 | Ring frequency select; 0 slow half period, 1 fast half period |
| ttx_req | input | 1 | Single-cycle metering-pulse request |
| ttx_len | input | TTX_W | Metering window length in clock cycles |
| cfg_deb | input | DEB_W | Debounce length in ticks, minus one |
| cfg_hang | input | TMR_W | Hang-up reference time in ticks |
| cfg_burst | input | TMR_W | Ring burst length in ticks |
| cfg_pause | input | TMR_W | Ring pause length in ticks |
| therm_fault | input | 1 | Thermal fault; forces power-down word and freezes state |
| det_n | input | 1 | Loop detector from the line device, active low |
| mode_pd | output | 1 | Mode word: power-enable bit |
| mode_d0 | output | 1 | Mode word: burst / metering bit |
| mode_d1 | output | 1 | Mode word: feed bit |
| mode_d2 | output | 1 | Mode word: polarity / ring toggle bit |
| line_state | output | 3 | 0 off, 1 idle, 2 active on-hook, 3 active off-hook, 4 burst, 5 pause |
| ring_rej | output | 1 | Ring request refused because the line was off-hook |

## Verification
The bench builds the block with TICK_DIV = 4 and short timer widths. One ring half period is then 100 or 80 clocks, and debounce, hang-up, burst and pause windows are a few dozen clocks. This lets one run measure exact toggle intervals at both frequencies, full burst/pause cycles, ring trip inside a long burst and hang-up timing against lower and upper bounds. Random metering lengths and polarities are drawn from a seeded generator and compared against a bench model of the mode word.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  typedef enum logic [2:0] {
    LS_OFF     = 3'd0,
    LS_IDLE    = 3'd1,
    LS_ACT_ON  = 3'd2,
    LS_ACT_OFF = 3'd3,
    LS_RING    = 3'd4,
    LS_PAUSE   = 3'd5
  } line_st_e;

  typedef struct packed {
    logic pd;
    logic d0;
    logic d1;
    logic d2;
  } mode_word_t;

  // Mode word for a given line state, metering flag, polarity and ring toggle.
  function automatic mode_word_t mode_of(line_st_e st, logic ttx, logic pol, logic tog);
    mode_word_t w;
    w = '0;
    unique case (st)
      LS_OFF:               w = '0;
      LS_IDLE:              w = '{pd: 1'b1, d0: 1'b0, d1: 1'b0, d2: 1'b0};
      LS_ACT_ON, LS_ACT_OFF: w = '{pd: 1'b1, d0: ttx,  d1: 1'b1, d2: pol};
      LS_RING:              w = '{pd: 1'b1, d0: 1'b1, d1: 1'b0, d2: tog};
      LS_PAUSE:             w = '{pd: 1'b1, d0: 1'b0, d1: 1'b1, d2: pol};
      default:              w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/lsc_prescale.sv
module lsc_prescale #(
  parameter int TICK_DIV = 125000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || cnt == CW'(TICK_DIV - 1)) cnt <= '0;
        else                                 cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(TICK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/lsc_det_filter.sv
module lsc_det_filter #(
  parameter int DEB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             det_n,
  input  logic [DEB_W-1:0] cfg_deb,
  output logic             off_hook
);
  logic s1, s2;
  logic [DEB_W-1:0] cnt;
  logic raw;

  assign raw = ~s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      cnt <= '0;
      off_hook <= 1'b0;
    end else begin
      s1 <= det_n;
      s2 <= s1;
      if (raw == off_hook) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt >= cfg_deb) begin
          off_hook <= raw;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3: the accepted level may only move on a tick
  assert_det_tick_only_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(off_hook));
endmodule

// File: rtl/lsc_ring_gen.sv
module lsc_ring_gen #(
  parameter int RING_HALF_SLOW = 25,
  parameter int RING_HALF_FAST = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic restart,
  input  logic f25,
  output logic tog
);
  localparam int HMAX = (RING_HALF_SLOW > RING_HALF_FAST) ? RING_HALF_SLOW : RING_HALF_FAST;
  localparam int HW   = $clog2(HMAX + 1);

  logic [HW-1:0] cnt, cnt_nx, half_sel;

  assign half_sel = f25 ? HW'(RING_HALF_FAST) : HW'(RING_HALF_SLOW);
  assign cnt_nx   = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
      tog <= 1'b0;
    end else if (run && tick) begin
      if (cnt_nx >= half_sel) begin
        cnt <= '0;
        tog <= ~tog;
      end else begin
        cnt <= cnt_nx;
      end
    end
  end

  // R10: outside a burst the toggle holds still
  assert_tog_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(tog));
endmodule

// File: rtl/line_state_ctrl.sv
module line_state_ctrl
  import lsc_pkg::*;
#(
  parameter int TICK_DIV       = 125000,
  parameter int DEB_W          = 4,
  parameter int TMR_W          = 12,
  parameter int TTX_W          = 16,
  parameter int RING_HALF_SLOW = 25,
  parameter int RING_HALF_FAST = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_en,
  input  logic             pol_rev,
  input  logic             ring_en,
  input  logic             ring_f25,
  input  logic             ttx_req,
  input  logic [TTX_W-1:0] ttx_len,
  input  logic [DEB_W-1:0] cfg_deb,
  input  logic [TMR_W-1:0] cfg_hang,
  input  logic [TMR_W-1:0] cfg_burst,
  input  logic [TMR_W-1:0] cfg_pause,
  input  logic             therm_fault,
  input  logic             det_n,
  output logic             mode_pd,
  output logic             mode_d0,
  output logic             mode_d1,
  output logic             mode_d2,
  output logic [2:0]       line_state,
  output logic             ring_rej
);
  localparam int PW = TMR_W + 1;

  logic tick, off_f, tog, ring_q, ring_rise, hold, is_act_n;
  line_st_e state_q, state_n;
  logic [TMR_W-1:0] hang_cnt, phase_cnt;
  logic [PW-1:0] phase_nx;
  logic [TTX_W-1:0] ttx_cnt;
  mode_word_t mode_q;
  logic burst_done, pause_done;

  lsc_prescale #(.TICK_DIV(TICK_DIV)) i_pre (.clk(clk), .rst(rst), .tick(tick));

  lsc_det_filter #(.DEB_W(DEB_W)) i_det (
    .clk(clk), .rst(rst), .tick(tick), .det_n(det_n), .cfg_deb(cfg_deb), .off_hook(off_f));

  lsc_ring_gen #(.RING_HALF_SLOW(RING_HALF_SLOW), .RING_HALF_FAST(RING_HALF_FAST)) i_ring (
    .clk(clk), .rst(rst), .tick(tick),
    .run(!hold && state_q == LS_RING),
    .restart(!hold && state_q != LS_RING && state_n == LS_RING),
    .f25(ring_f25), .tog(tog));

  assign hold       = therm_fault;
  assign ring_rise  = ring_en & ~ring_q;
  assign phase_nx   = PW'(phase_cnt) + PW'(1);
  assign burst_done = tick && (phase_nx >= PW'(cfg_burst));
  assign pause_done = tick && (phase_nx >= PW'(cfg_pause));
  assign is_act_n   = (state_n == LS_ACT_ON) || (state_n == LS_ACT_OFF);

  always_comb begin
    state_n = state_q;
    if (!hold) begin
      if (!line_en) state_n = LS_OFF;
      else begin
        unique case (state_q)
          LS_OFF:     state_n = LS_IDLE;
          LS_IDLE:    if (off_f) state_n = LS_ACT_OFF;
                      else if (ring_rise) state_n = LS_RING;
          LS_ACT_ON:  if (off_f) state_n = LS_ACT_OFF;
                      else if (ring_rise) state_n = LS_RING;
                      else if (tick && hang_cnt >= cfg_hang) state_n = LS_IDLE;
          LS_ACT_OFF: if (!off_f) state_n = LS_ACT_ON;
          LS_RING:    if (off_f) state_n = LS_ACT_OFF;
                      else if (!ring_en) state_n = LS_ACT_ON;
                      else if (burst_done) state_n = LS_PAUSE;
          LS_PAUSE:   if (off_f) state_n = LS_ACT_OFF;
                      else if (!ring_en) state_n = LS_ACT_ON;
                      else if (pause_done) state_n = LS_RING;
          default:    state_n = LS_OFF;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= LS_OFF;
      hang_cnt  <= '0;
      phase_cnt <= '0;
      ttx_cnt   <= '0;
      ring_q    <= 1'b0;
      ring_rej  <= 1'b0;
      mode_q    <= '0;
    end else begin
      ring_q  <= ring_en;
      state_q <= state_n;
      if (!hold) begin
        if (state_q == LS_ACT_ON && state_n == LS_ACT_ON) begin
          if (tick) hang_cnt <= hang_cnt + 1'b1;
        end else begin
          hang_cnt <= '0;
        end
        if (state_n != state_q) phase_cnt <= '0;
        else if ((state_q == LS_RING || state_q == LS_PAUSE) && tick) phase_cnt <= phase_cnt + 1'b1;
      end
      if (hold || !is_act_n)                ttx_cnt <= '0;
      else if (ttx_req && ttx_cnt == '0)    ttx_cnt <= ttx_len;
      else if (ttx_cnt != '0)               ttx_cnt <= ttx_cnt - 1'b1;
      if (!ring_en) ring_rej <= 1'b0;
      else if (ring_rise && off_f && line_en && !hold && state_q != LS_OFF) ring_rej <= 1'b1;
      mode_q <= hold ? '0 : mode_of(state_q, ttx_cnt != '0, pol_rev, tog);
    end
  end

  assign mode_pd    = mode_q.pd;
  assign mode_d0    = mode_q.d0;
  assign mode_d1    = mode_q.d1;
  assign mode_d2    = mode_q.d2;
  assign line_state = state_q;

  // R2: burst or feed bit never asserted without the power-enable bit
  assert_word_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_d0 || mode_d1) |-> mode_pd);
  // R7: return to idle from active on-hook only on a tick
  assert_hang_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == LS_ACT_ON && !tick) |=> state_q != LS_IDLE);
  // R10: ring trip leaves the burst on the next clock
  assert_ring_trip_R10: assert property (@(posedge clk) disable iff (rst)
    (!therm_fault && line_en && state_q == LS_RING && off_f) |=> state_q == LS_ACT_OFF);
  // R11: refusal flag only rises after an off-hook report
  assert_reject_offhook_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(ring_rej) |-> $past(off_f));
  // R12: fault gives the power-down word and freezes the state
  assert_fault_word_R12: assert property (@(posedge clk) disable iff (rst)
    therm_fault |=> (!mode_pd && !mode_d0 && !mode_d1 && !mode_d2));
  assert_fault_freeze_R12: assert property (@(posedge clk) disable iff (rst)
    therm_fault |=> $stable(state_q));
endmodule

// File: tb/test_line_state_ctrl.sv
module test_line_state_ctrl;
  localparam int TICK_DIV = 4;
  localparam int DEB_W = 4;
  localparam int TMR_W = 10;
  localparam int TTX_W = 8;
  localparam int HS = 25;
  localparam int HF = 20;

  logic clk = 1'b0;
  logic rst, line_en, pol_rev, ring_en, ring_f25, ttx_req, therm_fault, det_n;
  logic [TTX_W-1:0] ttx_len;
  logic [DEB_W-1:0] cfg_deb;
  logic [TMR_W-1:0] cfg_hang, cfg_burst, cfg_pause;
  logic mode_pd, mode_d0, mode_d1, mode_d2, ring_rej;
  logic [2:0] line_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  line_state_ctrl #(.TICK_DIV(TICK_DIV), .DEB_W(DEB_W), .TMR_W(TMR_W), .TTX_W(TTX_W),
                    .RING_HALF_SLOW(HS), .RING_HALF_FAST(HF)) i_line_state_ctrl (
    .clk(clk), .rst(rst), .line_en(line_en), .pol_rev(pol_rev), .ring_en(ring_en),
    .ring_f25(ring_f25), .ttx_req(ttx_req), .ttx_len(ttx_len), .cfg_deb(cfg_deb),
    .cfg_hang(cfg_hang), .cfg_burst(cfg_burst), .cfg_pause(cfg_pause),
    .therm_fault(therm_fault), .det_n(det_n), .mode_pd(mode_pd), .mode_d0(mode_d0),
    .mode_d1(mode_d1), .mode_d2(mode_d2), .line_state(line_state), .ring_rej(ring_rej));

  // Expected word from the requirement encodings: {pd,d0,d1,d2}
  function automatic int exp_word(int st, bit pol, bit tog);
    case (st)
      0: return 4'b0000;
      1: return 4'b1000;
      2, 3, 5: return {3'b101, pol};
      4: return {3'b110, tog};
      default: return 4'b0000;
    endcase
  endfunction

  function automatic int word();
    return {mode_pd, mode_d0, mode_d1, mode_d2};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ttx_pulse(int len, output int cnt, output int d1_low);
    ttx_len = TTX_W'(len);
    ttx_req = 1'b1;
    cyc(1);
    ttx_req = 1'b0;
    cnt = 0;
    d1_low = 0;
    for (int c = 0; c < len + 10; c++) begin
      cyc(1);
      if (mode_d0) cnt++;
      if (!mode_d1) d1_low++;
    end
  endtask

  task automatic toggle_gaps(output int g1, output int g2);
    int t[3];
    int n;
    bit prev;
    n = 0;
    prev = mode_d2;
    for (int c = 0; c < 300 && n < 3; c++) begin
      cyc(1);
      if (mode_d2 != prev) begin
        t[n] = c;
        n++;
        prev = mode_d2;
      end
    end
    g1 = (n == 3) ? t[1] - t[0] : -1;
    g2 = (n == 3) ? t[2] - t[1] : -1;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt, d1l, g1, g2, len, bad;
    bit pol;
    void'($urandom(32'd20240611));
    rst = 1'b1; line_en = 1'b0; pol_rev = 1'b0; ring_en = 1'b0; ring_f25 = 1'b0;
    ttx_req = 1'b0; ttx_len = '0; therm_fault = 1'b0; det_n = 1'b1;
    cfg_deb = 4'd2; cfg_hang = 10'd5; cfg_burst = 10'd90; cfg_pause = 10'd10;
    cyc(4);
    chk("R1 state", line_state, 0);
    chk("R1 word", word(), 0);
    chk("R1 ring_rej", ring_rej, 0);
    rst = 1'b0;
    cyc(5);
    chk("R2 disabled state", line_state, 0);
    chk("R2 disabled word", word(), exp_word(0, 0, 0));
    line_en = 1'b1;
    cyc(4);
    chk("R2 idle state", line_state, 1);
    chk("R2 idle word", word(), exp_word(1, 0, 0));

    // R3: one-clock detector glitch
    det_n = 1'b0; cyc(1); det_n = 1'b1;
    cyc(40);
    chk("R3 glitch ignored", line_state, 1);

    // R4: off-hook from idle
    det_n = 1'b0;
    cyc(30);
    chk("R4 off-hook state", line_state, 3);
    chk("R4 off-hook word", word(), exp_word(3, 0, 0));
    pol_rev = 1'b1; cyc(3);
    chk("R5 reverse polarity", word(), exp_word(3, 1, 0));

    // R6: random metering windows with random polarity
    for (int i = 0; i < 6; i++) begin
      len = 1 + int'($urandom % 40);
      pol = 1'($urandom);
      pol_rev = pol; cyc(3);
      ttx_pulse(len, cnt, d1l);
      chk("R6 metering length", cnt, len);
      chk("R6 feed bit held", d1l, 0);
      chk("R5 polarity after metering", word(), exp_word(3, pol, 0));
    end
    pol_rev = 1'b0;

    // R7: hang-up timing
    det_n = 1'b1;
    cyc(28);
    chk("R7 still active", line_state, 2);
    cyc(32);
    chk("R7 back to idle", line_state, 1);
    ttx_pulse(10, cnt, d1l);
    chk("R6 metering dropped in idle", cnt, 0);

    // R8: slow ring frequency
    ring_f25 = 1'b0; ring_en = 1'b1; cyc(2);
    chk("R9 ring starts", line_state, 4);
    toggle_gaps(g1, g2);
    chk("R8 slow half period 1", g1, HS * TICK_DIV);
    chk("R8 slow half period 2", g2, HS * TICK_DIV);
    ring_en = 1'b0; cyc(3);
    chk("R13 ring stop", line_state, 2);

    // R8: fast ring frequency
    ring_f25 = 1'b1; ring_en = 1'b1; cyc(2);
    toggle_gaps(g1, g2);
    chk("R8 fast half period 1", g1, HF * TICK_DIV);
    chk("R8 fast half period 2", g2, HF * TICK_DIV);
    ring_en = 1'b0; cyc(3);
    chk("R13 ring stop fast", line_state, 2);

    // R9: burst / pause cadence
    cfg_burst = 10'd10; cfg_pause = 10'd8; pol_rev = 1'b1;
    ring_en = 1'b1;
    cyc(20);
    chk("R9 in burst", line_state, 4);
    cyc(35);
    chk("R9 in pause", line_state, 5);
    chk("R9 pause word", word(), exp_word(5, 1, 0));
    cyc(35);
    chk("R9 burst again", line_state, 4);
    ring_en = 1'b0; cyc(3);
    pol_rev = 1'b0;

    // R10: ring trip in a long burst
    cfg_burst = 10'd200;
    ring_en = 1'b1; cyc(10);
    chk("R10 ringing before trip", line_state, 4);
    det_n = 1'b0;
    cyc(30);
    chk("R10 trip state", line_state, 3);
    chk("R10 trip word", word(), exp_word(3, 0, 0));
    bad = 0;
    for (int c = 0; c < 200; c++) begin
      cyc(1);
      if (mode_d2 != 1'b0) bad++;
    end
    chk("R10 toggle stopped", bad, 0);

    // R11: ring request while off-hook
    ring_en = 1'b0; cyc(2);
    chk("R11 flag idle", ring_rej, 0);
    ring_en = 1'b1; cyc(3);
    chk("R11 flag set", ring_rej, 1);
    chk("R11 no ringing", line_state, 3);
    ring_en = 1'b0; cyc(3);
    chk("R11 flag cleared", ring_rej, 0);

    // R12: thermal fault during a burst
    det_n = 1'b1; cyc(70);
    chk("R7 idle before fault test", line_state, 1);
    ring_en = 1'b1; cyc(10);
    chk("R12 ringing before fault", line_state, 4);
    therm_fault = 1'b1; cyc(3);
    chk("R12 fault word", word(), 0);
    cyc(50);
    chk("R12 fault word held", word(), 0);
    chk("R12 state frozen", line_state, 4);
    therm_fault = 1'b0; cyc(3);
    chk("R12 resumed state", line_state, 4);
    chk("R12 resumed word", word() >> 1, 3'b110);

    line_en = 1'b0; cyc(3);
    chk("R2 power down from ring", line_state, 0);
    chk("R2 power down word", word(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule